// File: doc/BRIEF.md
# Selectable-Order Sinc Decimator

This block turns a one-bit sigma-delta bitstream into 24-bit two's-complement samples. It is a cascaded integrator-comb filter whose order can be switched between three and four at run time by a single control input. A 10-bit rate word sets how many accepted modulator bits make up one output sample: sixteen per unit of the word. The filter's null frequencies therefore move with the output rate only and do not depend on the order chosen.

A strobe marks which clock cycles carry a modulator bit; the other cycles are ignored. A clear pulse, or any change of the order or rate inputs, empties every accumulator and delay. The output strobe then stays low until the filter window holds only samples taken after the restart. That is three output periods for the third-order response and four for the fourth-order one. Each result is the exact filter sum. It is shifted right by an amount that follows from the order and the rate, and then clamped to the 24-bit signed range.

Top module: `sincdec_top`

## Requirements
- R1: With `ord_hi_i` = 0, each result is the third-order response: the sum of the accepted samples weighted by three cascaded boxcars of length D. An accepted bit 1 counts as +1 and a bit 0 as -1. Samples from before the last restart count as 0.
- R2: With `ord_hi_i` = 1, each result is the fourth-order response, formed the same way from four cascaded boxcars of length D.
- R3: D = 16 × `fs_i`. One conversion finishes on every D-th accepted bit. Cycles with `bit_vld_i` = 0 change nothing.
- R4: A rate word of 0 behaves as a rate word of 1, so D = 16.
- R5: After a restart, the first N−1 conversions raise no strobe, where N is the selected order. The first `dvalid_o` pulse follows exactly N × D accepted bits.
- R6: A `clr_i` pulse clears all filter state, and the bit offered in the clear cycle is ignored. No earlier input affects any later result.
- R7: A change of `ord_hi_i` or `fs_i` from the previous cycle acts exactly like a `clr_i` pulse in that cycle.
- R8: Let B be the bit width of D. The sum is shifted right arithmetically by max(0, N × B − 23) bits and clamped to the range −2^23 to 2^23−1.
- R9: `dout_o` and `dvalid_o` are updated by the clock edge that accepts the completing bit. `dvalid_o` is high for one cycle, and `dout_o` holds its value between pulses.
- R10: While `rst_n` is low at a clock edge, `dout_o` becomes 0 and `dvalid_o` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mod_bit_i | input | 1 | Modulator bit (1 = +1, 0 = −1) |
| bit_vld_i | input | 1 | Marks a cycle that carries a modulator bit |
| ord_hi_i | input | 1 | 0 = third order, 1 = fourth order |
| fs_i | input | 10 | Rate word; D = 16 × fs_i |
| clr_i | input | 1 | Channel-change pulse: clears state, restarts settling |
| dout_o | output | 24 | Scaled, clamped two's-complement result |
| dvalid_o | output | 1 | One-cycle pulse for each settled result |

## Verification
Pseudo-random bitstreams at the smallest rates compare exact weighted sums against a kernel built by convolution in the bench. This separates the third- from the fourth-order kernel, and the unshifted from the one-bit-shifted scaling. Randomly gapped strobes show that idle cycles neither advance the decimation count nor enter the sum. Clear pulses and order or rate changes made mid-conversion, followed by constant input, show that stale state is gone and that the settling delay is three or four periods. Long constant runs of ones and zeros at a large rate check the shift amounts and floor rounding of R8 at both signs.

// File: rtl/sincdec_pkg.sv
// Shared sizing for the selectable-order sinc decimator.
// Assumes: the rate word scales the decimation by a fixed multiplier and the
// widest accumulator is set by the higher order at the largest ratio.
package sincdec_pkg;
    localparam int FS_W      = 10;
    localparam int RATE_MULT = 16;
    localparam int LO_ORD    = 3;
    localparam int HI_ORD    = 4;
    localparam int OUT_W     = 24;
    localparam int DEC_MAX   = RATE_MULT * ((1 << FS_W) - 1);
    localparam int DEC_W     = $clog2(DEC_MAX + 1);
    localparam int ACC_W     = HI_ORD * DEC_W + 1;
endpackage

// File: rtl/sincdec_integ.sv
// Integrator cascade: HI_ORD running sums, each fed by the new value of the
// stage before it in the same cycle, so stage k holds the k-fold sum including
// the current sample. Wrap-around arithmetic; the comb stages undo the wrap.
// Assumes: clr_i wins over en_i.
module sincdec_integ #(
    parameter int ORD_LO = 3,
    parameter int ORD_HI = 4,
    parameter int AW     = 57
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic          bit_i,
    output logic [AW-1:0] lo_o,
    output logic [AW-1:0] hi_o
);
    logic [AW-1:0] step;

    // map the modulator bit onto +1 / -1
    assign step = bit_i ? AW'(1) : {AW{1'b1}};

    for (genvar k = 0; k < ORD_HI; k++) begin : g_stg
        logic [AW-1:0] acc_q;
        logic [AW-1:0] nxt;
        if (k == 0) begin : g_head
            assign nxt = acc_q + step;
        end else begin : g_tail
            assign nxt = acc_q + g_stg[k-1].nxt;
        end
        // accumulate on every accepted bit, empty on reset or clear
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) acc_q <= '0;
            else if (en_i)       acc_q <= nxt;
        end
    end

    assign lo_o = g_stg[ORD_LO-1].nxt;
    assign hi_o = g_stg[ORD_HI-1].nxt;
endmodule

// File: rtl/sincdec_comb.sv
// Comb cascade at the decimated rate: each stage subtracts its input from
// one conversion earlier. All differences settle within the cycle of en_i.
// Assumes: en_i is high exactly in the cycle a conversion completes.
module sincdec_comb #(
    parameter int ORD_LO = 3,
    parameter int ORD_HI = 4,
    parameter int AW     = 57
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic [AW-1:0] din_i,
    output logic [AW-1:0] lo_o,
    output logic [AW-1:0] hi_o
);
    for (genvar k = 0; k < ORD_HI; k++) begin : g_cmb
        logic [AW-1:0] dly_q;
        logic [AW-1:0] src;
        logic [AW-1:0] diff;
        if (k == 0) begin : g_head
            assign src = din_i;
        end else begin : g_tail
            assign src = g_cmb[k-1].diff;
        end
        assign diff = src - dly_q;
        // remember this stage's input for the next conversion
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) dly_q <= '0;
            else if (en_i)       dly_q <= src;
        end
    end

    assign lo_o = g_cmb[ORD_LO-1].diff;
    assign hi_o = g_cmb[ORD_HI-1].diff;
endmodule

// File: rtl/sincdec_ctrl.sv
// Decimation counter and settling tracker. Flags the accepted bit that
// completes a conversion and whether that conversion is past settling.
// Assumes: dec_i only changes together with restart_i.
module sincdec_ctrl #(
    parameter int DW     = 14,
    parameter int ORD_HI = 4,
    localparam int CW    = $clog2(ORD_HI + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic          bit_vld_i,
    input  logic [DW-1:0] dec_i,
    input  logic [CW-1:0] ord_n_i,
    output logic          conv_done_o,
    output logic          conv_ok_o
);
    logic [DW-1:0] cnt_q;
    logic [CW-1:0] conv_q;

    assign conv_done_o = bit_vld_i && !restart_i && (cnt_q == dec_i - 1'b1);
    assign conv_ok_o   = conv_done_o &&
                         (({1'b0, conv_q} + 1'b1) >= {1'b0, ord_n_i});

    // count accepted bits within the current conversion
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) cnt_q <= '0;
        else if (bit_vld_i)      cnt_q <= conv_done_o ? '0 : cnt_q + 1'b1;
    end

    // count finished conversions since restart, saturating at the top order
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i)
            conv_q <= '0;
        else if (conv_done_o && (conv_q < CW'(ORD_HI)))
            conv_q <= conv_q + 1'b1;
    end

    assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |-> (cnt_q < dec_i));
endmodule

// File: rtl/sincdec_top.sv
// Selectable-order sinc decimator top. Tracks the configuration, derives the
// ratio and output shift, steers the chosen order, scales, clamps and
// registers the result.
// Assumes: one modulator bit per cycle at most; restart on clear or config change.
module sincdec_top
    import sincdec_pkg::*;
#(
    parameter int FS_BITS = FS_W,
    parameter int RATE    = RATE_MULT,
    parameter int ORD_LO  = LO_ORD,
    parameter int ORD_HI  = HI_ORD,
    parameter int RES_W   = OUT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mod_bit_i,
    input  logic               bit_vld_i,
    input  logic               ord_hi_i,
    input  logic [FS_BITS-1:0] fs_i,
    input  logic               clr_i,
    output logic [RES_W-1:0]   dout_o,
    output logic               dvalid_o
);
    localparam int DMAX = RATE * ((1 << FS_BITS) - 1);
    localparam int DB   = $clog2(DMAX + 1);
    localparam int AB   = ORD_HI * DB + 1;
    localparam int CW   = $clog2(ORD_HI + 1);
    localparam int BLW  = $clog2(DB + 1);
    localparam int SHW  = $clog2(ORD_HI * DB + 1);
    localparam longint PMAX = (64'sd1 <<< (RES_W - 1)) - 64'sd1;
    localparam logic signed [AB-1:0] POS_MAX = AB'(PMAX);
    localparam logic signed [AB-1:0] NEG_MIN = -POS_MAX - AB'(1);

    logic               cfg_ord_q;
    logic [FS_BITS-1:0] cfg_fs_q;
    logic               restart;
    logic [FS_BITS-1:0] fs_eff;
    logic [DB-1:0]      dec;
    logic [CW-1:0]      ord_n;
    logic [BLW-1:0]     blen;
    logic [SHW-1:0]     prod;
    logic [SHW-1:0]     shamt;
    logic               conv_done;
    logic               conv_ok;
    logic [AB-1:0]      int_lo, int_hi, cmb_lo, cmb_hi;
    logic signed [AB-1:0] shifted;
    logic [RES_W-1:0]   res;

    assign restart = clr_i || (ord_hi_i != cfg_ord_q) || (fs_i != cfg_fs_q);
    assign fs_eff  = (fs_i == '0) ? FS_BITS'(1) : fs_i;
    assign dec     = DB'(fs_eff) * DB'(RATE);
    assign ord_n   = ord_hi_i ? CW'(ORD_HI) : CW'(ORD_LO);

    sincdec_ctrl #(.DW(DB), .ORD_HI(ORD_HI)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .restart_i(restart), .bit_vld_i(bit_vld_i),
        .dec_i(dec), .ord_n_i(ord_n), .conv_done_o(conv_done), .conv_ok_o(conv_ok)
    );

    sincdec_integ #(.ORD_LO(ORD_LO), .ORD_HI(ORD_HI), .AW(AB)) integ_i (
        .clk(clk), .rst_n(rst_n), .clr_i(restart), .en_i(bit_vld_i),
        .bit_i(mod_bit_i), .lo_o(int_lo), .hi_o(int_hi)
    );

    sincdec_comb #(.ORD_LO(ORD_LO), .ORD_HI(ORD_HI), .AW(AB)) comb_i (
        .clk(clk), .rst_n(rst_n), .clr_i(restart), .en_i(conv_done),
        .din_i(ord_hi_i ? int_hi : int_lo), .lo_o(cmb_lo), .hi_o(cmb_hi)
    );

    // bit width of the ratio, used to size the output shift
    always_comb begin
        blen = '0;
        for (int i = 0; i < DB; i++)
            if (dec[i]) blen = BLW'(i + 1);
    end

    // drop low bits so the largest possible sum lands inside the result width
    always_comb begin
        prod    = SHW'(ord_n) * SHW'(blen);
        shamt   = (prod > SHW'(RES_W - 1)) ? prod - SHW'(RES_W - 1) : '0;
        shifted = $signed(ord_hi_i ? cmb_hi : cmb_lo) >>> shamt;
        if (shifted > POS_MAX)      res = POS_MAX[RES_W-1:0];
        else if (shifted < NEG_MIN) res = NEG_MIN[RES_W-1:0];
        else                        res = shifted[RES_W-1:0];
    end

    // register configuration and settled results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_ord_q <= ord_hi_i;
            cfg_fs_q  <= fs_i;
            dout_o    <= '0;
            dvalid_o  <= 1'b0;
        end else begin
            cfg_ord_q <= ord_hi_i;
            cfg_fs_q  <= fs_i;
            dvalid_o  <= conv_ok;
            if (conv_ok) dout_o <= res;
        end
    end

    assert_quiet_after_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !dvalid_o);
    assert_order_change_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ord_hi_i != cfg_ord_q) |=> !dvalid_o);
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid_o |=> !dvalid_o);
    assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dvalid_o |-> $stable(dout_o));
endmodule

// File: tb/sincdec_top_tb_top.sv
module sincdec_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mod_bit = 1'b0, bit_vld = 1'b0, ord_hi = 1'b0, clr = 1'b0;
    logic [9:0] fs = 10'd1;
    logic [23:0] dout_o;
    logic        dvalid_o;

    int    n_chk = 0, n_bad = 0;
    string cur_req = "R10";
    bit    done = 0;
    logic [15:0] lfsr = 16'hACE1;

    // behavioural reference state
    int     hist[$];
    int     h[];
    int     m_cnt = 0, m_conv = 0, m_D = 16, m_N = 3;
    logic   m_ord = 1'b0;
    logic [9:0] m_fs = 10'd1;
    bit     exp_v = 0, exp_known = 1;
    longint exp_dout = 0;

    always #4 clk = ~clk;

    sincdec_top dut_i (
        .clk(clk), .rst_n(rst_n), .mod_bit_i(mod_bit), .bit_vld_i(bit_vld),
        .ord_hi_i(ord_hi), .fs_i(fs), .clr_i(clr), .dout_o(dout_o), .dvalid_o(dvalid_o)
    );

    function automatic bit rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    function automatic longint ipow(longint b, int e);
        longint r = 1;
        for (int i = 0; i < e; i++) r = r * b;
        return r;
    endfunction

    function automatic longint scale(longint y, int d, int n);
        int sh = n * $clog2(d + 1) - 23;
        longint q;
        if (sh < 0) sh = 0;
        q = y >>> sh;
        if (q > 64'sd8388607) q = 64'sd8388607;
        if (q < -64'sd8388608) q = -64'sd8388608;
        return q;
    endfunction

    task automatic build_h();
        int tmp[];
        h = new[m_D];
        foreach (h[i]) h[i] = 1;
        for (int r = 1; r < m_N; r++) begin
            tmp = new[h.size() + m_D - 1];
            foreach (tmp[i]) tmp[i] = 0;
            for (int i = 0; i < h.size(); i++)
                for (int j = 0; j < m_D; j++) tmp[i+j] += h[i];
            h = tmp;
        end
    endtask

    task automatic chk(bit ok, string req, string what, longint got, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic compare();
        chk(dvalid_o === exp_v, cur_req, "dvalid", longint'(dvalid_o), longint'(exp_v));
        if (exp_known)
            chk(longint'($signed(dout_o)) == exp_dout, cur_req, "dout",
                longint'($signed(dout_o)), exp_dout);
    endtask

    task automatic model_step();
        int L;
        longint y;
        bit same;
        if (!rst_n || clr || ord_hi != m_ord || fs != m_fs) begin
            hist.delete();
            m_cnt = 0; m_conv = 0; exp_v = 0;
            m_ord = ord_hi; m_fs = fs;
            m_D = 16 * ((fs == 0) ? 1 : int'(fs));
            m_N = ord_hi ? 4 : 3;
            if (m_D <= 64) build_h();
            if (!rst_n) begin exp_dout = 0; exp_known = 1; end
        end else if (bit_vld) begin
            hist.push_front(mod_bit ? 1 : -1);
            L = m_N * (m_D - 1) + 1;
            while (hist.size() > L) void'(hist.pop_back());
            m_cnt++;
            exp_v = 0;
            if (m_cnt == m_D) begin
                m_cnt = 0;
                if (m_conv < m_N) m_conv++;
                if (m_conv >= m_N) begin
                    exp_v = 1;
                    same = (hist.size() == L);
                    for (int k = 1; k < hist.size() && same; k++)
                        if (hist[k] != hist[0]) same = 0;
                    if (same) begin
                        y = hist[0] * ipow(m_D, m_N);
                        exp_known = 1; exp_dout = scale(y, m_D, m_N);
                    end else if (m_D <= 64) begin
                        y = 0;
                        for (int k = 0; k < hist.size(); k++) y += longint'(h[k]) * hist[k];
                        exp_known = 1; exp_dout = scale(y, m_D, m_N);
                    end else exp_known = 0;
                end
            end
        end else exp_v = 0;
    endtask

    task automatic tick(logic r, logic b, logic v, logic o, logic [9:0] f, logic c);
        @(negedge clk);
        compare();
        rst_n = r; mod_bit = b; bit_vld = v; ord_hi = o; fs = f; clr = c;
        model_step();
    endtask

    task automatic run_rand(int cycles, logic o, logic [9:0] f, bit gaps);
        for (int i = 0; i < cycles; i++) tick(1, rnd(), gaps ? rnd() : 1'b1, o, f, 0);
    endtask

    task automatic run_const(int cycles, logic b, logic o, logic [9:0] f);
        for (int i = 0; i < cycles; i++) tick(1, b, 1, o, f, 0);
    endtask

    // first strobe after a clear must be seen after exactly N*D+1 ticks
    task automatic settle_time(string req, logic o, logic [9:0] f, int expect_t);
        int t = 0;
        tick(1, 1, 1, o, f, 1);
        do begin
            tick(1, rnd(), 1, o, f, 0);
            t++;
        end while (!dvalid_o && t < 5000);
        chk(t == expect_t, req, "ticks to first strobe", t, expect_t);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired during %s", cur_req);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        cur_req = "R10";
        for (int i = 0; i < 4; i++) tick(0, rnd(), 1, 0, 10'd1, 0);
        chk(dout_o == 24'd0 && dvalid_o == 1'b0, "R10", "reset outputs",
            longint'(dout_o), 0);
        // R1: third order, random stream
        cur_req = "R1";
        run_rand(16 * 10, 0, 10'd1, 0);
        // R2 / R7: order change restarts, fourth order random stream
        cur_req = "R2";
        run_rand(16 * 10, 1, 10'd1, 0);
        cur_req = "R2";
        run_rand(48 * 8, 1, 10'd3, 0);
        // R3: gapped strobe, ratio 32
        cur_req = "R3";
        run_rand(32 * 16, 1, 10'd2, 1);
        run_rand(32 * 16, 0, 10'd2, 1);
        // R4: rate word zero acts as one
        cur_req = "R4";
        run_rand(16 * 8, 0, 10'd0, 0);
        settle_time("R4", 0, 10'd0, 3 * 16 + 1);
        // R5: settling depends on order
        cur_req = "R5";
        settle_time("R5", 1, 10'd3, 4 * 48 + 1);
        settle_time("R5", 0, 10'd3, 3 * 48 + 1);
        // R6: mid-conversion clear, then ones; no trace of earlier input
        cur_req = "R6";
        run_rand(40, 1, 10'd1, 0);
        tick(1, 0, 1, 1, 10'd1, 1);
        run_const(90, 1, 1, 10'd1);
        chk(longint'($signed(dout_o)) == 65536, "R6", "dout after clear", 
            longint'($signed(dout_o)), 65536);
        // R7: order and rate changes mid-conversion
        cur_req = "R7";
        run_rand(100, 1, 10'd2, 0);
        run_rand(300, 0, 10'd2, 0);
        run_rand(20, 0, 10'd3, 0);
        run_rand(400, 0, 10'd3, 1);
        // R9: timing and hold with gaps
        cur_req = "R9";
        run_rand(16 * 24, 1, 10'd1, 1);
        // R8: large ratio, both signs, both orders
        cur_req = "R8";
        run_const(5 * 4800 + 10, 1, 1, 10'd300);
        chk(longint'($signed(dout_o)) == (ipow(4800, 4) >>> 29), "R8", "ones sinc4",
            longint'($signed(dout_o)), ipow(4800, 4) >>> 29);
        run_const(5 * 4800 + 10, 0, 1, 10'd300);
        chk(longint'($signed(dout_o)) == ((-ipow(4800, 4)) >>> 29), "R8", "zeros sinc4",
            longint'($signed(dout_o)), (-ipow(4800, 4)) >>> 29);
        run_const(4 * 4800 + 10, 1, 0, 10'd300);
        chk(longint'($signed(dout_o)) == (ipow(4800, 3) >>> 16), "R8", "ones sinc3",
            longint'($signed(dout_o)), ipow(4800, 3) >>> 16);
        tick(1, 0, 0, 0, 10'd300, 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule